// File: doc/BRIEF.md
# Serial Port Role and Mode-Fault Controller

This block sits beside the shift engine of a serial peripheral port. It takes the port enable, the requested master role and the fault-guard enable. From them it decides who owns the select pin, the serial clock pin and the master data-out pin. A pin is owned either by the general-purpose port logic (its direction and data bits) or by the serial function. When the port is a guarded master and another device pulls the select line low, the block reports a mode fault. The fault flag is sticky. While it is set, the block turns off the master's clock and data drivers and forces the effective role to slave, so that two masters never drive the same wires.

The block is a five-state machine. The states are:
- `ST_IDLE`: the port is off.
- `ST_SLAVE`: the port is a slave.
- `ST_MASTER_OPEN`: the port is a master and the select pin is left to the general-purpose logic.
- `ST_MASTER_GUARD`: the port is a master and the select pin is an input watched for faults.
- `ST_FAULT`: a mode fault has been latched.

The configuration bits are decoded into four rows: off, slave, open master and guarded master. From any state other than `ST_FAULT`, the machine moves each cycle to the state of the current row. The one exception is a select-low hit while the row is guarded master; that transition is "detect" and leads to `ST_FAULT`. From `ST_FAULT`, the machine leaves only on the clear strobe, and only if no new hit is present in the same cycle. That transition is "release", and it goes to the state of the current row. The select input is assumed to be already synchronized.

Top module: `spi_mode_ctrl`

## Requirements
- R1: During and right after reset the state is `ST_IDLE`. The clock and data-out enables are 0, the fault flag is 0, the effective-master output is 0, and the engine select (active low) is 1.
- R2: With enable=0 and no fault, the select pin's output enable and output data equal the port direction and data bits. The clock and data-out enables are 0. The engine select is 1 whatever the select pin level is, and a low select pin never sets the fault.
- R3: With enable=1 and master=0, the select output enable is 0 whatever the direction bit and the guard bit are. The engine select follows the pin. The clock and data-out enables are 0. A low select pin never sets the fault.
- R4: With enable=1, master=1 and guard=0, the select pin follows the port direction and data bits. The clock and data-out enables are 1, effective master is 1, and a low select pin never sets the fault.
- R5: With enable=1, master=1 and guard=1, the select output enable is 0 even when the direction bit is 1. The clock and data-out enables are 1.
- R6: With enable=1, master=1 and guard=1, a select level of 0 at a rising edge sets the fault flag in the cycle after that edge. The fault flag only rises after such a cycle.
- R7: While the fault flag is 1, the clock, data-out and select output enables are 0, and effective master is 0. The engine select follows the pin.
- R8: The fault flag stays 1 until a clear strobe arrives, even if the select pin returns high or enable drops.
- R9: A clear strobe during a fault removes the fault in the next cycle and enters the state of the current row. If the same cycle also has a guarded-master select-low hit, the fault stays. A strobe outside a fault changes nothing.
- R10: The clock and data-out enables, the fault flag and effective master change only one rising edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Serial port enable |
| master_i | input | 1 | Requested master role |
| guard_en_i | input | 1 | Arms fault detection for a master |
| sel_pin_i | input | 1 | Synchronized select pin level |
| gpio_dir_i | input | 1 | Port direction bit for the select pin (1 = output) |
| gpio_dat_i | input | 1 | Port data bit for the select pin |
| fault_clr_i | input | 1 | One-cycle clear strobe for the fault flag |
| sel_oe_o | output | 1 | Select pin output enable |
| sel_do_o | output | 1 | Select pin output data |
| sck_oe_o | output | 1 | Serial clock pin output enable |
| mosi_oe_o | output | 1 | Master data-out pin output enable |
| eng_sel_n_o | output | 1 | Select seen by the shift engine, active low |
| eff_master_o | output | 1 | Effective master role after fault forcing |
| fault_o | output | 1 | Sticky mode-fault flag |

## Verification
Two functions can land in the same cycle: the release of a latched fault by the clear strobe, and the detection of a fresh select-low hit. The bench provokes this by holding the select pin low in the guarded-master row while it pulses the clear strobe. It then expects the flag to stay 1 and the drivers to stay off. It also repeats the strobe with the pin high and expects the master role to return one edge later.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

    typedef enum logic [1:0] {
        CFG_OFF,
        CFG_SLAVE,
        CFG_MOPEN,
        CFG_MGUARD
    } cfg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLAVE,
        ST_MASTER_OPEN,
        ST_MASTER_GUARD,
        ST_FAULT
    } state_e;

    function automatic state_e cfg_to_state(cfg_e c);
        unique case (c)
            CFG_OFF:    return ST_IDLE;
            CFG_SLAVE:  return ST_SLAVE;
            CFG_MOPEN:  return ST_MASTER_OPEN;
            CFG_MGUARD: return ST_MASTER_GUARD;
            default:    return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/spi_mode_decode.sv
module spi_mode_decode
    import spi_mode_pkg::*;
(
    input  logic enable_i,
    input  logic master_i,
    input  logic guard_en_i,
    input  logic sel_pin_i,
    output cfg_e cfg_o,
    output logic hit_o
);
    always_comb begin
        if (!enable_i)       cfg_o = CFG_OFF;
        else if (!master_i)  cfg_o = CFG_SLAVE;
        else if (!guard_en_i) cfg_o = CFG_MOPEN;
        else                 cfg_o = CFG_MGUARD;
    end

    // select pulled low while armed as guarded master
    assign hit_o = (cfg_o == CFG_MGUARD) && !sel_pin_i;
endmodule

// File: rtl/spi_mode_fsm.sv
module spi_mode_fsm
    import spi_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cfg_e   cfg_i,
    input  logic   hit_i,
    input  logic   fault_clr_i,
    output state_e state_o
);
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_FAULT: begin
                // release only when no fresh hit in the same cycle
                if (fault_clr_i && !hit_i) state_d = cfg_to_state(cfg_i);
                else                       state_d = ST_FAULT;
            end
            ST_IDLE, ST_SLAVE, ST_MASTER_OPEN, ST_MASTER_GUARD: begin
                if (hit_i) state_d = ST_FAULT;
                else       state_d = cfg_to_state(cfg_i);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_mode_pins.sv
module spi_mode_pins
    import spi_mode_pkg::*;
(
    input  state_e state_i,
    input  logic   sel_pin_i,
    input  logic   gpio_dir_i,
    input  logic   gpio_dat_i,
    output logic   sel_oe_o,
    output logic   sel_do_o,
    output logic   sck_oe_o,
    output logic   mosi_oe_o,
    output logic   eng_sel_n_o,
    output logic   eff_master_o,
    output logic   fault_o
);
    always_comb begin
        sel_oe_o     = 1'b0;
        sel_do_o     = gpio_dat_i;
        sck_oe_o     = 1'b0;
        mosi_oe_o    = 1'b0;
        eng_sel_n_o  = 1'b1;
        eff_master_o = 1'b0;
        fault_o      = 1'b0;
        unique case (state_i)
            ST_IDLE: begin
                sel_oe_o = gpio_dir_i;
            end
            ST_SLAVE: begin
                eng_sel_n_o = sel_pin_i;
            end
            ST_MASTER_OPEN: begin
                sel_oe_o     = gpio_dir_i;
                sck_oe_o     = 1'b1;
                mosi_oe_o    = 1'b1;
                eff_master_o = 1'b1;
            end
            ST_MASTER_GUARD: begin
                sck_oe_o     = 1'b1;
                mosi_oe_o    = 1'b1;
                eff_master_o = 1'b1;
            end
            ST_FAULT: begin
                eng_sel_n_o = sel_pin_i;
                fault_o     = 1'b1;
            end
            default: begin
                sel_oe_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
    import spi_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic master_i,
    input  logic guard_en_i,
    input  logic sel_pin_i,
    input  logic gpio_dir_i,
    input  logic gpio_dat_i,
    input  logic fault_clr_i,
    output logic sel_oe_o,
    output logic sel_do_o,
    output logic sck_oe_o,
    output logic mosi_oe_o,
    output logic eng_sel_n_o,
    output logic eff_master_o,
    output logic fault_o
);
    cfg_e   cfg;
    logic   hit;
    state_e state;

    spi_mode_decode u_decode (
        .enable_i   (enable_i),
        .master_i   (master_i),
        .guard_en_i (guard_en_i),
        .sel_pin_i  (sel_pin_i),
        .cfg_o      (cfg),
        .hit_o      (hit)
    );

    spi_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .hit_i       (hit),
        .fault_clr_i (fault_clr_i),
        .state_o     (state)
    );

    spi_mode_pins u_pins (
        .state_i      (state),
        .sel_pin_i    (sel_pin_i),
        .gpio_dir_i   (gpio_dir_i),
        .gpio_dat_i   (gpio_dat_i),
        .sel_oe_o     (sel_oe_o),
        .sel_do_o     (sel_do_o),
        .sck_oe_o     (sck_oe_o),
        .mosi_oe_o    (mosi_oe_o),
        .eng_sel_n_o  (eng_sel_n_o),
        .eff_master_o (eff_master_o),
        .fault_o      (fault_o)
    );
endmodule

// File: rtl/spi_mode_ctrl_chk.sv
module spi_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic master_i,
    input logic guard_en_i,
    input logic sel_pin_i,
    input logic fault_clr_i,
    input logic sel_oe_o,
    input logic sck_oe_o,
    input logic mosi_oe_o,
    input logic eff_master_o,
    input logic fault_o
);
    logic armed_hit;
    logic live_q;

    assign armed_hit = enable_i && master_i && guard_en_i && !sel_pin_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_fault_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_hit |=> fault_o);

    p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $rose(fault_o)) |-> $past(armed_hit));

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!sck_oe_o && !mosi_oe_o && !sel_oe_o && !eff_master_o));

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_clr_i) |=> fault_o);

    p_fault_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && fault_clr_i && !armed_hit) |=> !fault_o);

    p_slave_sel_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(enable_i && !master_i) && !fault_o) |-> !sel_oe_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!enable_i) && !fault_o) |-> (!sck_oe_o && !mosi_oe_o));
endmodule

bind spi_mode_ctrl spi_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .master_i     (master_i),
    .guard_en_i   (guard_en_i),
    .sel_pin_i    (sel_pin_i),
    .fault_clr_i  (fault_clr_i),
    .sel_oe_o     (sel_oe_o),
    .sck_oe_o     (sck_oe_o),
    .mosi_oe_o    (mosi_oe_o),
    .eff_master_o (eff_master_o),
    .fault_o      (fault_o)
);

// File: tb/tb_spi_mode_ctrl.sv
`timescale 1ns/1ps
module tb_spi_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 0, master_i = 0, guard_en_i = 0, sel_pin_i = 1;
    logic gpio_dir_i = 0, gpio_dat_i = 0, fault_clr_i = 0;
    logic sel_oe_o, sel_do_o, sck_oe_o, mosi_oe_o, eng_sel_n_o, eff_master_o, fault_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .master_i(master_i),
        .guard_en_i(guard_en_i), .sel_pin_i(sel_pin_i), .gpio_dir_i(gpio_dir_i),
        .gpio_dat_i(gpio_dat_i), .fault_clr_i(fault_clr_i), .sel_oe_o(sel_oe_o),
        .sel_do_o(sel_do_o), .sck_oe_o(sck_oe_o), .mosi_oe_o(mosi_oe_o),
        .eng_sel_n_o(eng_sel_n_o), .eff_master_o(eff_master_o), .fault_o(fault_o)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(logic en, logic ms, logic gd);
        enable_i = en; master_i = ms; guard_en_i = gd;
    endtask

    task automatic strobe_clr();
        fault_clr_i = 1'b1;
        tick();
        fault_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        gpio_dir_i = 1'b1; gpio_dat_i = 1'b1;
        #1;
        chk("R1", "sel_oe in reset", sel_oe_o, 1'b1);
        chk("R1", "sck_oe in reset", sck_oe_o, 1'b0);
        chk("R1", "mosi_oe in reset", mosi_oe_o, 1'b0);
        chk("R1", "fault in reset", fault_o, 1'b0);
        chk("R1", "eff_master in reset", eff_master_o, 1'b0);
        chk("R1", "eng_sel_n in reset", eng_sel_n_o, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1", "fault after reset", fault_o, 1'b0);
    endtask

    task automatic t_disabled();
        set_cfg(0, 1, 1);
        sel_pin_i = 1'b0; gpio_dir_i = 1'b1; gpio_dat_i = 1'b0;
        tick(2);
        chk("R2", "sel_oe follows dir=1", sel_oe_o, 1'b1);
        chk("R2", "sel_do follows dat=0", sel_do_o, 1'b0);
        chk("R2", "sck_oe off", sck_oe_o, 1'b0);
        chk("R2", "mosi_oe off", mosi_oe_o, 1'b0);
        chk("R2", "engine select ignores low pin", eng_sel_n_o, 1'b1);
        chk("R2", "no fault from low pin", fault_o, 1'b0);
        gpio_dir_i = 1'b0;
        #1;
        chk("R2", "sel_oe follows dir=0", sel_oe_o, 1'b0);
    endtask

    task automatic t_slave();
        set_cfg(1, 0, 1);
        gpio_dir_i = 1'b1; sel_pin_i = 1'b0;
        tick(2);
        chk("R3", "sel_oe off in slave", sel_oe_o, 1'b0);
        chk("R3", "engine select low", eng_sel_n_o, 1'b0);
        chk("R3", "sck_oe off in slave", sck_oe_o, 1'b0);
        chk("R3", "mosi_oe off in slave", mosi_oe_o, 1'b0);
        chk("R3", "no fault in slave", fault_o, 1'b0);
        sel_pin_i = 1'b1;
        #1;
        chk("R3", "engine select follows pin high", eng_sel_n_o, 1'b1);
    endtask

    task automatic t_open_master();
        set_cfg(1, 1, 0);
        gpio_dir_i = 1'b1; gpio_dat_i = 1'b0; sel_pin_i = 1'b0;
        #1;
        chk("R10", "sck_oe waits for edge", sck_oe_o, 1'b0);
        tick();
        chk("R10", "sck_oe after edge", sck_oe_o, 1'b1);
        tick();
        chk("R4", "sel_oe follows dir", sel_oe_o, 1'b1);
        chk("R4", "sel_do follows dat", sel_do_o, 1'b0);
        chk("R4", "mosi_oe on", mosi_oe_o, 1'b1);
        chk("R4", "eff_master on", eff_master_o, 1'b1);
        chk("R4", "engine select high", eng_sel_n_o, 1'b1);
        chk("R4", "no fault from low pin", fault_o, 1'b0);
        strobe_clr();
        chk("R9", "stray strobe keeps master", eff_master_o, 1'b1);
        chk("R9", "stray strobe keeps fault 0", fault_o, 1'b0);
    endtask

    task automatic t_guard_and_fault();
        sel_pin_i = 1'b1;
        set_cfg(1, 1, 1);
        gpio_dir_i = 1'b1;
        tick();
        chk("R5", "sel_oe off despite dir", sel_oe_o, 1'b0);
        chk("R5", "sck_oe on", sck_oe_o, 1'b1);
        chk("R5", "mosi_oe on", mosi_oe_o, 1'b1);
        sel_pin_i = 1'b0;
        #1;
        chk("R10", "fault waits for edge", fault_o, 1'b0);
        tick();
        chk("R6", "fault set", fault_o, 1'b1);
        chk("R7", "sck_oe off", sck_oe_o, 1'b0);
        chk("R7", "mosi_oe off", mosi_oe_o, 1'b0);
        chk("R7", "eff_master forced 0", eff_master_o, 1'b0);
        chk("R7", "sel_oe off", sel_oe_o, 1'b0);
        chk("R7", "engine select follows pin", eng_sel_n_o, 1'b0);
    endtask

    task automatic t_sticky();
        sel_pin_i = 1'b1;
        tick(2);
        chk("R8", "fault holds with pin high", fault_o, 1'b1);
        set_cfg(0, 0, 0);
        tick(3);
        chk("R8", "fault holds with enable low", fault_o, 1'b1);
        chk("R8", "sck_oe stays off", sck_oe_o, 1'b0);
    endtask

    task automatic t_clear();
        gpio_dir_i = 1'b1;
        strobe_clr();
        chk("R9", "clear drops fault", fault_o, 1'b0);
        chk("R9", "idle row after clear", sel_oe_o, 1'b1);
        set_cfg(1, 1, 1);
        sel_pin_i = 1'b0;
        tick();
        chk("R6", "fault set again", fault_o, 1'b1);
        strobe_clr();
        chk("R9", "clear loses to fresh hit", fault_o, 1'b1);
        chk("R9", "drivers stay off", sck_oe_o, 1'b0);
        sel_pin_i = 1'b1;
        strobe_clr();
        chk("R9", "clear with pin high", fault_o, 1'b0);
        chk("R9", "master returns", eff_master_o, 1'b1);
        chk("R9", "sck_oe returns", sck_oe_o, 1'b1);
    endtask

    initial begin
        #150000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_disabled();
        t_slave();
        t_open_master();
        t_guard_and_fault();
        t_sticky();
        t_clear();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule